// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Run-Time Frame Format

This block is the sending side of a byte-oriented asynchronous serial link. A CPU writes one byte at a time into a holding register. Whenever the output shifter is free, and transmission is enabled, the byte moves into the shifter and goes out on the serial line as a complete frame: a low start bit, the data bits, an optional parity bit and a high stop period. Between frames the line rests high.

An 8-bit format byte sets the frame shape at run time: the bit period in ticks of the transmit clock enable (1, 16 or 64), the data width (5 to 8 bits), the parity (off, odd or even) and the stop length (1, 1.5 or 2 bits). Two flags report progress to the CPU. One shows that the holding register can take another byte. The other shows that the shifter is idle. The format byte is meant to be written only while the shifter is idle.

Top module: `utx_top`

## Requirements
- R1: After reset the serial line is high, the ready flag and the empty flag are both high, and the format byte is 0x00, which starts no frame.
- R2: Format bits [1:0] set the bit period: 01 is one enable tick, 10 is 16 ticks and 11 is 64 ticks. With 00, no frame starts. Ticks are counted only in cycles where `txclk_en` is high. A tick in the cycle that loads a frame does not count toward that frame.
- R3: Every frame begins with a low start bit. Format bits [3:2] = n then give 5+n data bits, sent least significant bit first.
- R4: Format bit 4 = 1 adds a parity bit after the data bits. Format bit 5 = 1 selects even parity (the data bits plus the parity bit hold an even number of ones), and 0 selects odd parity. Parity covers only the configured data bits.
- R5: Format bits [7:6] set the high stop period: 00 or 01 is one bit period, 11 is two bit periods, and 10 is 1.5 bit periods (24 ticks at ×16, 96 at ×64, and 2 ticks at ×1).
- R6: A CPU write fills the holding register. Its byte moves to the shifter as soon as the shifter is idle, or in the same cycle as the last stop tick, so frames can follow each other with no gap. A write to a full holding register replaces the byte held there.
- R7: `tx_ready` is high exactly when the holding register is empty. It is low in the cycle after a write.
- R8: `tx_empty` goes low in the cycle after a frame is loaded. It returns high after the final stop tick, unless the next frame is loaded in that same cycle.
- R9: No frame starts while `xmit_en` is low. A frame already in progress runs to completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txclk_en | input | 1 | Transmit clock tick, one clock cycle wide |
| mode_we | input | 1 | Write strobe for the format byte |
| mode_byte | input | 8 | Format byte: [1:0] period, [3:2] width, [4] parity on, [5] even, [7:6] stop |
| xmit_en | input | 1 | Transmit enable |
| wr_en | input | 1 | CPU byte write strobe |
| wr_data | input | 8 | CPU byte |
| txd | output | 1 | Serial output, high when idle |
| tx_ready | output | 1 | Holding register empty |
| tx_empty | output | 1 | Shifter idle |

## Verification
The bench targets the following corner cases, and each one shows up as a wrong value on `txd` or on one of the flags:
- **Fractional stop length at every period.** A design that scales 1.5 stop bits wrongly sends a stop period that is too short or too long. This is worst at ×1, where the period must round up to two ticks.
- **Parity with a 5-bit word.** A design that folds unused upper byte bits into the parity sends a wrong parity bit whenever those bits are set.
- **Back-to-back frames.** A reload that waits one extra cycle after the last stop tick stretches the stop period by one cycle.
- **Sparse ticks.** A counter that advances on the system clock rather than on the tick runs the frames too fast.
- **Overwrite while full.** A holding register that refuses a second write sends the older byte.
- **Gating.** Starting a frame with the enable low, or with a period field of 00, drops the empty flag when it should stay high.

// File: rtl/utx_pkg.sv
package utx_pkg;
  localparam int UTX_DATA_W  = 8;
  localparam int UTX_FRAME_W = UTX_DATA_W + 3;
  localparam int UTX_LEFT_W  = 4;

  typedef struct packed {
    logic [1:0] stop_sel;
    logic       par_even;
    logic       par_en;
    logic [1:0] len_sel;
    logic [1:0] div_sel;
  } utx_mode_t;
endpackage

// File: rtl/utx_mode_dec.sv
module utx_mode_dec
  import utx_pkg::*;
#(
  parameter int DIV_MID = 16,
  parameter int DIV_HI  = 64,
  parameter int TICK_W  = 8
) (
  input  utx_mode_t         mode,
  output logic              div_ok,
  output logic [TICK_W-1:0] bit_ticks,
  output logic [TICK_W-1:0] stop_ticks,
  output logic [3:0]        data_len,
  output logic              par_en,
  output logic              par_even
);
  always_comb begin
    div_ok = 1'b1;
    case (mode.div_sel)
      2'b01:   bit_ticks = TICK_W'(1);
      2'b10:   bit_ticks = TICK_W'(DIV_MID);
      2'b11:   bit_ticks = TICK_W'(DIV_HI);
      default: begin
        bit_ticks = TICK_W'(1);
        div_ok    = 1'b0;
      end
    endcase
  end

  always_comb begin
    case (mode.stop_sel)
      2'b10:   stop_ticks = (mode.div_sel == 2'b01) ? TICK_W'(2)
                                                    : bit_ticks + (bit_ticks >> 1);
      2'b11:   stop_ticks = bit_ticks << 1;
      default: stop_ticks = bit_ticks;
    endcase
  end

  assign data_len = 4'd5 + {2'b00, mode.len_sel};
  assign par_en   = mode.par_en;
  assign par_even = mode.par_even;
endmodule

// File: rtl/utx_hold.sv
module utx_hold
  import utx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [UTX_DATA_W-1:0] wr_data,
  input  logic                  take,
  output logic                  full,
  output logic [UTX_DATA_W-1:0] data
);
  logic                  full_q, full_d;
  logic [UTX_DATA_W-1:0] data_q, data_d;

  always_comb begin
    full_d = (full_q & ~take) | wr_en;
    data_d = data_q;
    if (wr_en) data_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      if (wr_en) data_q <= data_d;
    end
  end

  assign full = full_q;
  assign data = data_q;
endmodule

// File: rtl/utx_framer.sv
module utx_framer
  import utx_pkg::*;
#(
  parameter int DIV_HI = 64,
  parameter int TICK_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  start_ok,
  input  logic [UTX_DATA_W-1:0] data,
  input  logic [3:0]            data_len,
  input  logic                  par_en,
  input  logic                  par_even,
  input  logic [TICK_W-1:0]     bit_ticks,
  input  logic [TICK_W-1:0]     stop_ticks,
  output logic                  take,
  output logic                  txd,
  output logic                  busy
);
  localparam int FW = UTX_FRAME_W;

  logic [FW-1:0]         shreg_q, shreg_d, frame;
  logic [UTX_LEFT_W-1:0] left_q, left_d, nbits;
  logic [TICK_W-1:0]     cnt_q, cnt_d;
  logic                  busy_q, busy_d;
  logic [UTX_DATA_W-1:0] mask;
  logic                  par_bit, stop_phase, done;

  // frame image, LSB first: start, data, optional parity, ones
  always_comb begin
    for (int i = 0; i < UTX_DATA_W; i++) mask[i] = (i < int'(data_len));
    par_bit = (^(data & mask)) ^ ~par_even;
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < UTX_DATA_W; i++) begin
      if (i < int'(data_len))                    frame[i+1] = data[i];
      else if ((i == int'(data_len)) && par_en)  frame[i+1] = par_bit;
    end
    if ((data_len == 4'd8) && par_en) frame[UTX_DATA_W+1] = par_bit;
    nbits = 4'd1 + data_len + {3'b000, par_en};
  end

  always_comb begin
    stop_phase = (left_q == '0);
    done       = busy_q && tick && stop_phase && (cnt_q == stop_ticks - TICK_W'(1));
    take       = start_ok && (!busy_q || done);
    shreg_d    = shreg_q;
    left_d     = left_q;
    cnt_d      = cnt_q;
    busy_d     = busy_q;
    if (take) begin
      busy_d  = 1'b1;
      shreg_d = frame;
      left_d  = nbits;
      cnt_d   = '0;
    end else if (busy_q && tick) begin
      if (stop_phase) begin
        if (done) begin
          busy_d = 1'b0;
          cnt_d  = '0;
        end else begin
          cnt_d = cnt_q + TICK_W'(1);
        end
      end else if (cnt_q == bit_ticks - TICK_W'(1)) begin
        shreg_d = {1'b1, shreg_q[FW-1:1]};
        left_d  = left_q - UTX_LEFT_W'(1);
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + TICK_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '1;
      left_q  <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
    end else begin
      shreg_q <= shreg_d;
      left_q  <= left_d;
      cnt_q   <= cnt_d;
      busy_q  <= busy_d;
    end
  end

  assign txd  = shreg_q[0];
  assign busy = busy_q;

  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> txd); // R1
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (!txd && busy_q)); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q < TICK_W'(2 * DIV_HI))); // R5
  AST_BITS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    left_q <= UTX_LEFT_W'(FW - 1)); // R3
endmodule

// File: rtl/utx_top.sv
module utx_top
  import utx_pkg::*;
#(
  parameter int DIV_MID = 16,
  parameter int DIV_HI  = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       txclk_en,
  input  logic       mode_we,
  input  logic [7:0] mode_byte,
  input  logic       xmit_en,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic       txd,
  output logic       tx_ready,
  output logic       tx_empty
);
  localparam int TICK_W = $clog2(2 * DIV_HI + 1);

  logic [1:0]        rst_sync;
  logic              rst_s;
  logic [7:0]        mode_q;
  utx_mode_t         mode_s;
  logic              div_ok, par_en, par_even, take, hold_full, busy, start_ok;
  logic [TICK_W-1:0] bit_ticks, stop_ticks;
  logic [3:0]        data_len;
  logic [7:0]        hold_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)       mode_q <= '0;
    else if (mode_we) mode_q <= mode_byte;
  end
  assign mode_s = utx_mode_t'(mode_q);

  utx_mode_dec #(.DIV_MID(DIV_MID), .DIV_HI(DIV_HI), .TICK_W(TICK_W)) u_dec (
    .mode(mode_s), .div_ok(div_ok), .bit_ticks(bit_ticks), .stop_ticks(stop_ticks),
    .data_len(data_len), .par_en(par_en), .par_even(par_even));

  utx_hold u_hold (
    .clk(clk), .rst_n(rst_s), .wr_en(wr_en), .wr_data(wr_data), .take(take),
    .full(hold_full), .data(hold_data));

  assign start_ok = hold_full & xmit_en & div_ok;

  utx_framer #(.DIV_HI(DIV_HI), .TICK_W(TICK_W)) u_framer (
    .clk(clk), .rst_n(rst_s), .tick(txclk_en), .start_ok(start_ok), .data(hold_data),
    .data_len(data_len), .par_en(par_en), .par_even(par_even), .bit_ticks(bit_ticks),
    .stop_ticks(stop_ticks), .take(take), .txd(txd), .busy(busy));

  assign tx_ready = ~hold_full;
  assign tx_empty = ~busy;

  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_s)
    wr_en |=> !tx_ready); // R7
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_s)
    (!xmit_en && tx_empty) |=> tx_empty); // R9
  AST_NO_SYNC_START: assert property (@(posedge clk) disable iff (!rst_s)
    ((mode_q[1:0] == 2'b00) && tx_empty) |=> tx_empty); // R2
endmodule

// File: tb/utx_top_bench.sv
module utx_top_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txclk_en = 1'b0;
  logic mode_we = 1'b0;
  logic [7:0] mode_byte = '0;
  logic xmit_en = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic txd, tx_ready, tx_empty;

  int checks = 0;
  int errors = 0;
  int tick_every = 1;
  int tick_cnt = 0;
  bit cmp_on = 1'b0;
  string cur_req = "R1";

  // reference model state
  bit m_busy, m_full;
  logic [7:0] m_hold, m_mode;
  bit q[$];

  utx_top u_utx_top (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    tick_cnt = tick_cnt + 1;
    if (tick_cnt >= tick_every) begin
      tick_cnt = 0;
      txclk_en <= 1'b1;
    end else begin
      txclk_en <= 1'b0;
    end
  end

  task automatic build_frame(input logic [7:0] d, input logic [7:0] m);
    int div, len, ones, st;
    bit p;
    div = (m[1:0] == 2'b01) ? 1 : (m[1:0] == 2'b10) ? 16 : 64;
    len = 5 + int'(m[3:2]);
    ones = 0;
    for (int i = 0; i < len; i++) ones += int'(d[i]);
    p = m[5] ? bit'(ones % 2) : !bit'(ones % 2);
    for (int k = 0; k < div; k++) q.push_back(1'b0);
    for (int i = 0; i < len; i++)
      for (int k = 0; k < div; k++) q.push_back(d[i]);
    if (m[4]) for (int k = 0; k < div; k++) q.push_back(p);
    if (m[7:6] == 2'b10)      st = (div == 1) ? 2 : div * 3 / 2;
    else if (m[7:6] == 2'b11) st = 2 * div;
    else                      st = div;
    for (int k = 0; k < st; k++) q.push_back(1'b1);
  endtask

  always @(posedge clk) begin
    bit done, can;
    if (!rst_n) begin
      m_busy = 0; m_full = 0; m_hold = '0; m_mode = '0; q.delete();
    end else begin
      done = 0;
      if (m_busy && txclk_en) begin
        void'(q.pop_front());
        if (q.size() == 0) done = 1;
      end
      can = m_full && xmit_en && (m_mode[1:0] != 2'b00) && (!m_busy || done);
      if (can) begin
        build_frame(m_hold, m_mode);
        m_busy = 1; m_full = 0;
      end else if (done) begin
        m_busy = 0;
      end
      if (wr_en) begin m_full = 1; m_hold = wr_data; end
      if (mode_we) m_mode = mode_byte;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      logic exp_txd;
      exp_txd = m_busy ? q[0] : 1'b1;
      check(txd === exp_txd, cur_req, "txd", int'(txd), int'(exp_txd));
      check(tx_empty === !m_busy, "R8", "tx_empty", int'(tx_empty), int'(!m_busy));
      check(tx_ready === !m_full, "R7", "tx_ready", int'(tx_ready), int'(!m_full));
    end
  end

  task automatic cpu_write(input logic [7:0] b);
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic set_mode(input logic [7:0] m);
    @(negedge clk); mode_we = 1'b1; mode_byte = m;
    @(negedge clk); mode_we = 1'b0;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 20000; n++) begin
      @(negedge clk);
      if (tx_empty && tx_ready) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic measure(input int exp, input string req);
    int n = 0;
    for (int k = 0; k < 2000 && tx_empty; k++) @(negedge clk);
    while (!tx_empty && n < 5000) begin n++; @(negedge clk); end
    check(n == exp, req, "frame length in cycles", n, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(txd === 1'b1, "R1", "txd after reset", int'(txd), 1);
    check(tx_ready === 1'b1, "R1", "tx_ready after reset", int'(tx_ready), 1);
    check(tx_empty === 1'b1, "R1", "tx_empty after reset", int'(tx_empty), 1);
    cmp_on = 1'b1;

    // R2: format 0x00 leaves a held byte untouched even when enabled
    cur_req = "R2"; xmit_en = 1'b1;
    cpu_write(8'h5A);
    repeat (30) @(negedge clk);
    check(tx_empty === 1'b1, "R2", "no start with period field 00", int'(tx_empty), 1);
    check(tx_ready === 1'b0, "R2", "byte still held", int'(tx_ready), 0);

    // R3 R6: 8 data bits, x1, back to back frames
    cur_req = "R3"; set_mode(8'h4D);
    wait_idle();
    cur_req = "R6";
    cpu_write(8'hA5);
    cpu_write(8'h3C);
    cpu_write(8'hC3);
    wait_idle();

    // R4: 7 bits even parity, 2 stop, x16, sparse ticks
    cur_req = "R4"; tick_every = 3; set_mode(8'hFA);
    cpu_write(8'hD5);
    wait_idle();
    tick_every = 1;

    // R4 R5: 5 bits odd parity, 1.5 stop at x16, upper bits must not affect parity
    cur_req = "R4"; set_mode(8'h92);
    cpu_write(8'hE1);
    measure(7 * 16 + 24, "R5");
    wait_idle();

    // R5: 6 bits, 1.5 stop at x64
    cur_req = "R5"; set_mode(8'h87);
    cpu_write(8'h2B);
    measure(7 * 64 + 96, "R5");
    wait_idle();

    // R5: 1.5 stop at x1 rounds to two ticks; two stop bits at x1
    set_mode(8'h8D);
    cpu_write(8'h96);
    measure(9 + 2, "R5");
    wait_idle();
    set_mode(8'hDD);
    cpu_write(8'h0F);
    measure(10 + 2, "R5");
    wait_idle();

    // R9 R6: disabled, overwrite held byte, then enable and drop enable mid-frame
    cur_req = "R9"; xmit_en = 1'b0; set_mode(8'h5E);
    cpu_write(8'h11);
    cpu_write(8'h22);
    repeat (40) @(negedge clk);
    check(tx_empty === 1'b1, "R9", "no frame while disabled", int'(tx_empty), 1);
    check(tx_ready === 1'b0, "R6", "held byte kept", int'(tx_ready), 0);
    @(negedge clk); xmit_en = 1'b1;
    repeat (40) @(negedge clk); xmit_en = 1'b0;
    cpu_write(8'h77);
    wait_idle();
    check(tx_ready === 1'b0, "R9", "queued byte waits for enable", int'(tx_ready), 0);
    xmit_en = 1'b1;
    wait_idle();

    cmp_on = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule